// File: doc/BRIEF.md
# Armed Run-of-Ones Detector

This block watches a single serial bit stream `x` that is synchronous to the clock and raises `z` once the stream carries a run of `RUN_LEN` (default four) back-to-back ones. The detector starts disarmed. Ones that arrive before the first zero after reset are discarded. The first zero arms the detector. From then on, any zero clears the run count, and every one adds to it.

`z` is a Mealy output. It is a function of the present state and the present value of `x`, so it rises in the same cycle as the qualifying one. Once the count reaches its limit it holds there, and `z` stays high on each further one until a zero arrives.

The state fits in three D flip-flops. Codes that encode no state fall back to idle on the next clock, whatever `x` is. For test, a mode input turns the state flip-flops into a shift chain, so any code can be loaded through `scan_in` and read back on `scan_out`.

Top module: `rof_detector`

## Requirements
- R1: While `rst_n` is low, the state is idle (code 000), `z` is 0 and `scan_out` is 0, whatever `x` is.
- R2: Before the first 0 after reset, a 1 on `x` leaves the machine idle and `z` stays 0.
- R3: After arming, `z` is 1 in the same cycle that the fourth consecutive 1 is present on `x`, not one cycle later.
- R4: While armed, a 0 on `x` returns the state to armed-with-zero-count (code 001), so a fresh run of four ones is needed.
- R5: After the fourth 1, the count saturates (code 100) and `z` stays 1 on every further consecutive 1. The first 0 drops it.
- R6: The unused codes 101, 110 and 111 move to idle (000) on the next clock when `test_mode` is 0, for either value of `x`. In these codes `z` is 0.
- R7: When `test_mode` is 1, each clock shifts the state one place toward the MSB. `scan_in` enters bit 0, and `scan_out` always shows bit 2. The state codes are: idle 000, armed 001, one 1 seen 010, two 011, three or more 100.
- R8: When `test_mode` is 1, `z` is 0.
- R9: Reset overrides test mode. A low `rst_n` forces idle even while `test_mode` is 1 and shifting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| x | input | 1 | Serial data bit, synchronous to `clk` |
| test_mode | input | 1 | 1 selects the scan shift path for the state flip-flops |
| scan_in | input | 1 | Serial data shifted into state bit 0 in test mode |
| z | output | 1 | Mealy detect output |
| scan_out | output | 1 | State bit 2, the end of the scan chain |

## Verification
The assertions assume that `x`, `test_mode` and `scan_in` are stable around the rising edge and change only once per cycle. The bench respects this by driving every input on the falling edge.

The properties also assume that `rst_n` is released away from the active edge. The bench deasserts it at a falling edge.

An unused state code can only be reached through the scan path. The bench therefore loads each unused code in test mode, leaves test mode for exactly one functional clock, and reads the result back through the chain.

// File: rtl/rof_pkg.sv
package rof_pkg;
  // Fixed state codes; the run-count codes follow from the run length.
  localparam int unsigned IDLE_CODE = 0;  // disarmed, no zero seen yet
  localparam int unsigned ARM_CODE  = 1;  // armed, run count zero

  // Width of the state register for a given run length.
  function automatic int unsigned state_width(input int unsigned run_len);
    return $clog2(run_len + 1);
  endfunction
endpackage

// File: rtl/rof_next.sv
module rof_next #(
  parameter int unsigned RUN_LEN = 4,
  parameter int unsigned SW      = rof_pkg::state_width(RUN_LEN)
) (
  input  logic [SW-1:0] state_q,
  input  logic          x,
  output logic [SW-1:0] state_d
);
  localparam logic [SW-1:0] IDLE_C = SW'(rof_pkg::IDLE_CODE);
  localparam logic [SW-1:0] ARM_C  = SW'(rof_pkg::ARM_CODE);
  localparam logic [SW-1:0] TOP_C  = SW'(RUN_LEN);

  always_comb begin
    state_d = IDLE_C;
    if (state_q > TOP_C) begin
      state_d = IDLE_C;                       // unused code: recover
    end else if (state_q == IDLE_C) begin
      state_d = x ? IDLE_C : ARM_C;           // ones ignored until a zero
    end else if (!x) begin
      state_d = ARM_C;                        // zero clears the run
    end else if (state_q == TOP_C) begin
      state_d = TOP_C;                        // saturate
    end else begin
      state_d = state_q + SW'(1);
    end
  end
endmodule

// File: rtl/rof_out.sv
module rof_out #(
  parameter int unsigned RUN_LEN = 4,
  parameter int unsigned SW      = rof_pkg::state_width(RUN_LEN)
) (
  input  logic [SW-1:0] state_q,
  input  logic          x,
  input  logic          test_mode,
  output logic          z
);
  localparam logic [SW-1:0] TOP_C = SW'(RUN_LEN);

  always_comb begin
    z = 1'b0;
    if (!test_mode && x && (state_q == TOP_C)) begin
      z = 1'b1;
    end
  end
endmodule

// File: rtl/rof_state_reg.sv
module rof_state_reg #(
  parameter int unsigned SW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          test_mode,
  input  logic          scan_in,
  input  logic [SW-1:0] func_d,
  output logic [SW-1:0] state_q,
  output logic          scan_out
);
  logic [SW-1:0] reg_d;

  always_comb begin
    if (test_mode) begin
      reg_d = {state_q[SW-2:0], scan_in};
    end else begin
      reg_d = func_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= '0;
    end else begin
      state_q <= reg_d;
    end
  end

  assign scan_out = state_q[SW-1];

  // R7: in test mode the register shifts toward the MSB
  assert_scan_shift_R7: assert property (@(posedge clk) disable iff (!rst_n)
    test_mode |=> (state_q == {$past(state_q[SW-2:0]), $past(scan_in)}));
  // R7: the chain end shows the MSB after each shift
  assert_scan_out_R7: assert property (@(posedge clk) disable iff (!rst_n)
    test_mode |=> (scan_out == $past(state_q[SW-2])));
endmodule

// File: rtl/rof_detector.sv
module rof_detector #(
  parameter int unsigned RUN_LEN = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic x,
  input  logic test_mode,
  input  logic scan_in,
  output logic z,
  output logic scan_out
);
  localparam int unsigned SW = rof_pkg::state_width(RUN_LEN);
  localparam logic [SW-1:0] IDLE_C = SW'(rof_pkg::IDLE_CODE);
  localparam logic [SW-1:0] ARM_C  = SW'(rof_pkg::ARM_CODE);
  localparam logic [SW-1:0] TOP_C  = SW'(RUN_LEN);

  logic [SW-1:0] state_q;
  logic [SW-1:0] func_d;

  rof_next #(.RUN_LEN(RUN_LEN), .SW(SW)) u_next (
    .state_q (state_q),
    .x       (x),
    .state_d (func_d)
  );

  rof_out #(.RUN_LEN(RUN_LEN), .SW(SW)) u_out (
    .state_q   (state_q),
    .x         (x),
    .test_mode (test_mode),
    .z         (z)
  );

  rof_state_reg #(.SW(SW)) u_reg (
    .clk       (clk),
    .rst_n     (rst_n),
    .test_mode (test_mode),
    .scan_in   (scan_in),
    .func_d    (func_d),
    .state_q   (state_q),
    .scan_out  (scan_out)
  );

  // R2: ones before the first zero keep the machine idle
  assert_idle_holds_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!test_mode && state_q == IDLE_C && x) |=> (state_q == IDLE_C));
  // R4: a zero from any legal state lands in the armed state
  assert_zero_rearms_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!test_mode && !x && state_q <= TOP_C) |=> (state_q == ARM_C));
  // R5: a detect is followed by the saturated count
  assert_detect_saturates_R5: assert property (@(posedge clk) disable iff (!rst_n)
    z |=> (state_q == TOP_C));
  // R6: unused codes fall back to idle
  assert_illegal_to_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!test_mode && state_q > TOP_C) |=> (state_q == IDLE_C));
  // R8: no detect while scanning
  assert_quiet_in_test_R8: assert property (@(posedge clk) disable iff (!rst_n)
    test_mode |-> !z);
endmodule

// File: tb/test_rof_detector.sv
module test_rof_detector;
  localparam int RUN_LEN = 4;
  localparam int SW      = 3;
  localparam int NVEC    = 24;

  // {x, expected z}, applied from idle right after reset
  localparam logic [1:0] VEC [NVEC] = '{
    2'b10, 2'b10, 2'b00, 2'b10, 2'b10, 2'b10, 2'b11, 2'b11,
    2'b00, 2'b10, 2'b10, 2'b10, 2'b00, 2'b10, 2'b10, 2'b10,
    2'b11, 2'b00, 2'b00, 2'b10, 2'b10, 2'b10, 2'b11, 2'b11
  };

  logic clk = 1'b0;
  logic rst_n, x, test_mode, scan_in;
  logic z, scan_out;
  int   checks = 0;
  int   errors = 0;
  bit   done = 0;

  always #2 clk = ~clk;

  rof_detector #(.RUN_LEN(RUN_LEN)) i_rof_detector (
    .clk(clk), .rst_n(rst_n), .x(x), .test_mode(test_mode),
    .scan_in(scan_in), .z(z), .scan_out(scan_out)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic chk_code(input string req, input logic [SW-1:0] act, input logic [SW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic cyc(input logic xi, input logic tm, input logic si);
    @(negedge clk);
    x = xi; test_mode = tm; scan_in = si;
    #1;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; x = 1'b1; test_mode = 1'b0; scan_in = 1'b0;
    #1;
    chk("R1 z in reset", z, 1'b0);
    chk("R1 scan_out in reset", scan_out, 1'b0);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic load_state(input logic [SW-1:0] code);
    for (int i = SW - 1; i >= 0; i--) cyc(1'b0, 1'b1, code[i]);
  endtask

  task automatic read_state(output logic [SW-1:0] code);
    for (int i = SW - 1; i >= 0; i--) begin
      cyc(1'b0, 1'b1, 1'b0);
      code[i] = scan_out;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [SW-1:0] rd;
    bit armed;
    int cnt;
    logic xr, zexp;

    rst_n = 1'b0; x = 1'b0; test_mode = 1'b0; scan_in = 1'b0;
    do_reset();

    // Table walk: R2 ignore, R3 detect, R4 clear, R5 saturation
    for (int i = 0; i < NVEC; i++) begin
      cyc(VEC[i][1], 1'b0, 1'b0);
      chk("R2/R3/R4/R5 vector", z, VEC[i][0]);
    end

    // R2: many ones straight after reset never detect
    do_reset();
    for (int i = 0; i < 8; i++) begin
      cyc(1'b1, 1'b0, 1'b0);
      chk("R2 disarmed", z, 1'b0);
    end
    cyc(1'b0, 1'b0, 1'b0);
    read_state(rd);
    chk_code("R4 armed code", rd, 3'b001);

    // R7: scan load and read back of a legal code
    load_state(3'b011);
    read_state(rd);
    chk_code("R7 scan readback", rd, 3'b011);

    // R3: Mealy detect in the same cycle from the saturated code
    load_state(3'b100);
    cyc(1'b1, 1'b0, 1'b0);
    chk("R3 same-cycle z", z, 1'b1);
    cyc(1'b1, 1'b1, 1'b0);
    chk("R8 z in test mode", z, 1'b0);
    chk("R7 scan_out msb", scan_out, 1'b1);

    // R6: every unused code returns to idle for either x
    for (int c = 5; c < 8; c++) begin
      for (int xv = 0; xv < 2; xv++) begin
        load_state(3'(c));
        cyc(1'(xv), 1'b0, 1'b0);
        chk("R6 z in unused code", z, 1'b0);
        read_state(rd);
        chk_code("R6 recover to idle", rd, 3'b000);
      end
    end

    // R9: reset wins over test mode
    load_state(3'b010);
    @(negedge clk);
    rst_n = 1'b0; test_mode = 1'b1; scan_in = 1'b1;
    repeat (2) @(negedge clk);
    rst_n = 1'b1; scan_in = 1'b0;
    #1;
    chk("R9 scan_out after reset", scan_out, 1'b0);
    read_state(rd);
    chk_code("R9 idle after reset in test", rd, 3'b000);

    // Random stream against a behavioural model
    do_reset();
    armed = 0; cnt = 0;
    for (int i = 0; i < 3000; i++) begin
      xr = ($urandom_range(0, 4) != 0);
      cyc(xr, 1'b0, 1'b0);
      zexp = armed && xr && (cnt >= RUN_LEN - 1);
      chk("R3/R5 random", z, zexp);
      if (!armed) begin
        if (!xr) begin armed = 1; cnt = 0; end
      end else if (xr) begin
        if (cnt < RUN_LEN) cnt++;
      end else begin
        cnt = 0;
      end
    end

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule